// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block drives the data bus of a 32-bit synchronous SRAM. Each rising clock edge captures a command: a chip-select decode from three enables, a read/write flag and a sleep request. The memory array answers a captured read with combinational data in the following cycle. A static mode input then picks one of two output paths. In the bypass path the array word goes straight to the bus in the cycle after the read is captured. In the registered path the word passes through a rising-edge output register and reaches the bus one cycle later.

Output drive is set by three things: the pipeline state, an asynchronous active-low output enable, and the sleep input. Deselects take the short route. In registered mode a deselect releases the bus one edge after it is captured, so the bus goes high-Z right after the last read word. Any captured write releases the bus at once. Sleep forces high-Z and turns every command presented during it into a deselect. The output register keeps its contents through sleep.

Top module: `rdo_stage`

## Requirements
- R1: A command is selected only when `cs1_n` and `cs3_n` are both 0 and `cs2` is 1 at the rising edge. Any other combination is captured as a deselect, and the bus is not driven for it.
- R2: With `mode_pipe` = 0, a read captured at edge k drives `bus_dq` = `rd_data` in the cycle after edge k.
- R3: With `mode_pipe` = 1, the `rd_data` value present just before edge k+1 is held by the output register. For a read captured at edge k, that value is driven in the cycle after edge k+1, even if `rd_data` changes afterwards.
- R4: With `mode_pipe` = 1, a deselect captured at edge j releases the bus in the cycle after edge j+1. The word of a read captured at edge j-1 is therefore still delivered, and the bus is never held into a second cycle.
- R5: While `oe_n` is 1, `bus_oe` is 0 at once, whatever the clocked state.
- R6: In the cycle after a write is captured, `bus_oe` is 0 in both modes.
- R7: Whenever the bus is driven, all four lanes are driven together: `bus_oe` is either 4'b0000 or 4'b1111, with lane i covering bits 8i+7..8i.
- R8: While `sleep` is 1, `bus_oe` is 0. A command presented at an edge where `sleep` is 1 is treated as a deselect and never reaches the bus.
- R9: After reset, and whenever `bus_oe` is 0, `bus_dq` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pipe | input | 1 | 1 = registered output path, 0 = bypass path |
| cs1_n | input | 1 | Active-low chip enable |
| cs2 | input | 1 | Active-high chip enable |
| cs3_n | input | 1 | Active-low chip enable |
| cmd_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| sleep | input | 1 | Low-power request, active high |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rd_data | input | 32 | Array word for the read captured at the last edge |
| bus_dq | output | 32 | Data presented to the bus drivers |
| bus_oe | output | 4 | Per-lane drive enable |

## Verification
In registered mode, a read delivery and a deselect or write can fall in the same cycle. A deselect placed right after a read burst must let the final word out and then release the bus one cycle later. A write in that position must kill the word. The bench runs both orderings and predicts the bus from its own model of the captured command history.

The asynchronous enable and sleep can also land on a cycle that would otherwise deliver a word. The bench toggles them in the middle of a burst and checks that the bus goes quiet in exactly those cycles and recovers afterwards.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    typedef enum logic [1:0] {
        CMD_DES = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2
    } cmd_e;

    typedef struct packed {
        cmd_e cmd;
    } cap_st_t;
endpackage

// File: rtl/rdo_capture.sv
module rdo_capture
    import rdo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs1_n,
    input  logic cs2,
    input  logic cs3_n,
    input  logic cmd_wr,
    input  logic sleep,
    output cmd_e s1_cmd
);
    cap_st_t st_d, st_q;
    logic    sel;

    always_comb begin
        st_d = st_q;
        sel  = !cs1_n && !cs3_n && cs2;
        if (sleep || !sel) st_d.cmd = CMD_DES;
        else if (cmd_wr)   st_d.cmd = CMD_WR;
        else               st_d.cmd = CMD_RD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cmd: CMD_DES};
        else        st_q <= st_d;
    end

    assign s1_cmd = st_q.cmd;
endmodule

// File: rtl/rdo_outreg.sv
module rdo_outreg
    import rdo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              s1_cmd,
    input  logic              sleep,
    input  logic [DATA_W-1:0] rd_data,
    output logic              s2_rd,
    output logic [DATA_W-1:0] s2_data
);
    typedef struct packed {
        logic              rd;
        logic [DATA_W-1:0] data;
    } oreg_t;

    oreg_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.rd = (s1_cmd == CMD_RD) && !sleep;
        if (st_d.rd) st_d.data = rd_data;   // hold contents otherwise
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s2_rd   = st_q.rd;
    assign s2_data = st_q.data;
endmodule

// File: rtl/rdo_drive.sv
module rdo_drive
    import rdo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              mode_pipe,
    input  logic              oe_n,
    input  logic              sleep,
    input  cmd_e              s1_cmd,
    input  logic              s2_rd,
    input  logic [DATA_W-1:0] s2_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] bus_dq,
    output logic [LANES-1:0]  bus_oe
);
    localparam int LANE_W = DATA_W / LANES;

    logic              drv;
    logic [DATA_W-1:0] src;

    always_comb begin
        if (mode_pipe) begin
            drv = s2_rd && (s1_cmd != CMD_WR);
            src = s2_data;
        end else begin
            drv = (s1_cmd == CMD_RD);
            src = rd_data;
        end
        drv = drv && !oe_n && !sleep;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bus_oe[i] = drv;
        assign bus_dq[i*LANE_W +: LANE_W] = drv ? src[i*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/rdo_stage.sv
module rdo_stage
    import rdo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pipe,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              cmd_wr,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] bus_dq,
    output logic [LANES-1:0]  bus_oe
);
    cmd_e              s1_cmd;
    logic              s2_rd;
    logic [DATA_W-1:0] s2_data;

    rdo_capture u_cap (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .cmd_wr(cmd_wr), .sleep(sleep), .s1_cmd(s1_cmd)
    );

    rdo_outreg #(.DATA_W(DATA_W)) u_oreg (
        .clk(clk), .rst_n(rst_n), .s1_cmd(s1_cmd), .sleep(sleep),
        .rd_data(rd_data), .s2_rd(s2_rd), .s2_data(s2_data)
    );

    rdo_drive #(.DATA_W(DATA_W), .LANES(LANES)) u_drv (
        .mode_pipe(mode_pipe), .oe_n(oe_n), .sleep(sleep), .s1_cmd(s1_cmd),
        .s2_rd(s2_rd), .s2_data(s2_data), .rd_data(rd_data),
        .bus_dq(bus_dq), .bus_oe(bus_oe)
    );
endmodule

// File: rtl/rdo_stage_chk.sv
module rdo_stage_chk #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_pipe,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              cmd_wr,
    input logic              sleep,
    input logic              oe_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] bus_dq,
    input logic [LANES-1:0]  bus_oe
);
    logic [1:0] age_q;
    logic       rd_go, wr_go;

    assign rd_go = !cs1_n && !cs3_n && cs2 && !cmd_wr && !sleep;
    assign wr_go = !cs1_n && !cs3_n && cs2 &&  cmd_wr && !sleep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2) age_q <= age_q + 2'd1;
    end

    AST_OE_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> bus_oe == '0);                                          // R5
    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == '0) || (bus_oe == '1));                               // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == '0) |-> bus_dq == '0);                                // R9
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> bus_oe == '0);                                         // R8
    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0) && $past(wr_go) |-> bus_oe == '0);                  // R6
    AST_FLOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0) && !mode_pipe && $past(rd_go) && !oe_n && !sleep
        |-> (bus_oe == '1) && (bus_dq == rd_data));                      // R2
    AST_PIPE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0) && mode_pipe && (bus_oe != '0)
        |-> bus_dq == $past(rd_data));                                   // R3
    AST_SCD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2) && mode_pipe && !$past(rd_go, 2) |-> bus_oe == '0); // R4
endmodule

bind rdo_stage rdo_stage_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .cs1_n(cs1_n),
    .cs2(cs2), .cs3_n(cs3_n), .cmd_wr(cmd_wr), .sleep(sleep), .oe_n(oe_n),
    .rd_data(rd_data), .bus_dq(bus_dq), .bus_oe(bus_oe)
);

// File: tb/test_rdo_stage.sv
module test_rdo_stage;
    localparam int DW = 32;
    localparam int LN = 4;

    logic          clk = 0, rst_n = 0;
    logic          mode_pipe = 0, cs1_n = 1, cs2 = 0, cs3_n = 1, cmd_wr = 0;
    logic          sleep = 0, oe_n = 0;
    logic [DW-1:0] rd_data = '0;
    logic [DW-1:0] bus_dq;
    logic [LN-1:0] bus_oe;

    int errors = 0, checks = 0;

    typedef struct {
        logic          oe;
        logic [DW-1:0] dq;
        string         tag;
    } exp_t;
    exp_t sb_q[$];

    // bench-side command history: 0 = deselect, 1 = read, 2 = write
    int            m_c1 = 0;
    logic          m_c2 = 0;
    logic [DW-1:0] m_c2d = '0;
    logic          p_sel = 0, p_wr = 0, p_zz = 0;
    logic [DW-1:0] p_d = '0;

    always #2 clk = ~clk;

    rdo_stage #(.DATA_W(DW), .LANES(LN)) i_rdo_stage (
        .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .cs1_n(cs1_n),
        .cs2(cs2), .cs3_n(cs3_n), .cmd_wr(cmd_wr), .sleep(sleep),
        .oe_n(oe_n), .rd_data(rd_data), .bus_dq(bus_dq), .bus_oe(bus_oe)
    );

    task automatic check(input logic ok, input string tag, input logic [DW+LN-1:0] act,
                         input logic [DW+LN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual oe/dq=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle. The command arguments apply to the next edge;
    // d, zz, oen and mode hold for the cycle just begun.
    task automatic step(input logic mode, input logic c1n, input logic c2,
                        input logic c3n, input logic w, input logic [DW-1:0] d,
                        input logic zz, input logic oen, input string tag);
        exp_t e;
        int   nc1;
        @(posedge clk);
        nc1   = p_zz ? 0 : (p_sel ? (p_wr ? 2 : 1) : 0);
        m_c2  = (m_c1 == 1) && !p_zz;
        if (m_c2) m_c2d = p_d;
        m_c1  = nc1;
        #1;
        mode_pipe = mode; cs1_n = c1n; cs2 = c2; cs3_n = c3n; cmd_wr = w;
        rd_data = d; sleep = zz; oe_n = oen;
        p_sel = !c1n && c2 && !c3n; p_wr = w; p_zz = zz; p_d = d;
        if (mode) begin
            e.oe = m_c2 && (m_c1 != 2);
            e.dq = m_c2d;
        end else begin
            e.oe = (m_c1 == 1);
            e.dq = d;
        end
        e.oe = e.oe && !oen && !zz;
        if (!e.oe) e.dq = '0;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic rd(input logic m, input logic [DW-1:0] d, input string t);
        step(m, 0, 1, 0, 0, d, 0, 0, t);
    endtask
    task automatic ds(input logic m, input logic [DW-1:0] d, input string t);
        step(m, 1, 0, 1, 0, d, 0, 0, t);
    endtask
    task automatic wr(input logic m, input logic [DW-1:0] d, input string t);
        step(m, 0, 1, 0, 1, d, 0, 0, t);
    endtask

    // Monitor: compares mid-cycle, away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [LN-1:0] eo;
            e  = sb_q.pop_front();
            eo = e.oe ? '1 : '0;
            check(bus_oe === eo && bus_dq === e.dq, e.tag, {bus_oe, bus_dq}, {eo, e.dq});
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(bus_oe === '0 && bus_dq === '0, "R9 reset", {bus_oe, bus_dq}, '0);
        rst_n = 1;

        // R2 R7: bypass burst of reads then release
        ds(0, 32'h0, "R9 idle");
        rd(0, 32'h0, "R2 pre");
        rd(0, 32'h1111_0001, "R2 beat1");
        rd(0, 32'h2222_0002, "R2 beat2");
        rd(0, 32'h3333_0003, "R7 beat3");
        ds(0, 32'h4444_0004, "R2 beat4");
        ds(0, 32'h5555_0005, "R2 released");

        // R1: each enable wrong in turn
        step(0, 1, 1, 0, 0, 32'h0, 0, 0, "R1 pre");
        step(0, 0, 0, 0, 0, 32'hAAAA_0001, 0, 0, "R1 cs1_n high");
        step(0, 0, 1, 1, 0, 32'hAAAA_0002, 0, 0, "R1 cs2 low");
        step(0, 0, 1, 0, 0, 32'hAAAA_0003, 0, 0, "R1 cs3_n high");
        ds(0, 32'hAAAA_0004, "R1 selected read");
        ds(0, 32'h0, "R1 tail");

        // R3 R4: registered burst, deselect right after last read
        rd(1, 32'h0, "R3 pre");
        rd(1, 32'hB000_0001, "R3 first");
        rd(1, 32'hB000_0002, "R3 beat2");
        rd(1, 32'hB000_0003, "R3 beat3");
        ds(1, 32'hB000_0004, "R3 beat4");
        ds(1, 32'hDEAD_BEEF, "R4 last word out");
        ds(1, 32'h0, "R4 released");
        ds(1, 32'h0, "R4 quiet");

        // R6: write after reads in registered mode kills the word
        rd(1, 32'h0, "R6 pre");
        rd(1, 32'hC000_0001, "R6 read1");
        wr(1, 32'hC000_0002, "R6 read2");
        ds(1, 32'hC000_0003, "R6 write hiz");
        ds(1, 32'h0, "R6 after");
        // R6 bypass mode write
        wr(0, 32'h0, "R6 pre bypass");
        ds(0, 32'hC100_0001, "R6 bypass write hiz");

        // R5: async enable mid-burst
        rd(0, 32'h0, "R5 pre");
        rd(0, 32'hD000_0001, "R5 on");
        step(0, 0, 1, 0, 0, 32'hD000_0002, 0, 1, "R5 oe_n high");
        step(0, 0, 1, 0, 0, 32'hD000_0003, 0, 1, "R5 oe_n high2");
        ds(0, 32'hD000_0004, "R5 back on");
        ds(0, 32'h0, "R5 tail");

        // R8: sleep in registered mode; reads during sleep are ignored
        rd(1, 32'h0, "R8 pre");
        rd(1, 32'hE000_0001, "R8 prime");
        step(1, 0, 1, 0, 0, 32'hE000_0002, 1, 0, "R8 sleep on");
        step(1, 0, 1, 0, 0, 32'hE000_0003, 1, 0, "R8 sleep held");
        ds(1, 32'hE000_0004, "R8 cmd at sleep edge ignored");
        ds(1, 32'hE000_0005, "R8 still quiet");
        // R8 bypass
        rd(0, 32'h0, "R8 bypass pre");
        step(0, 1, 0, 1, 0, 32'hE100_0001, 1, 0, "R8 bypass sleep");
        ds(0, 32'hE100_0002, "R8 bypass ignored");
        ds(0, 32'h0, "R9 end");

        @(posedge clk);
        @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule